// File: doc/BRIEF.md
# Speculative Hold Controller with Level-1 Timeout

This block drives the single shared hold line of a track-and-hold analog front end. A fast pretrigger raises hold, and every channel's sample is frozen before the slower level-1 accept decision is known. The block then keeps hold high for a bounded window of clock cycles while it waits for that accept. If no accept arrives, hold drops when the window ends and the block can take a new pretrigger on the next cycle. If an accept does arrive, the block sends a one-cycle readout request to the downstream sequencer. It then keeps hold high until the sequencer reports that readout has finished.

The window length is the parameter `WIN_CYCLES`, counted in clock cycles. Its default is 120, which is 1.2 µs at a 100 MHz clock. The `busy` output tells neighbouring logic when the controller is not idle.

Top module: `hold_gate_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `hold`, `busy` and `readout_start` are all low.
- R2: A pretrigger sampled while idle drives `hold` and `busy` high from the next cycle.
- R3: Once armed and with no level-1 seen, `hold` stays high for exactly `WIN_CYCLES` consecutive cycles.
- R4: If no level-1 is sampled during those `WIN_CYCLES` cycles, `hold` and `busy` go low on the following cycle.
- R5: After a timeout, a pretrigger sampled on the first idle cycle arms the block again. There is no extra dead time.
- R6: A level-1 sampled during any cycle of the window, including the last one, makes `readout_start` high for exactly one cycle, on the next cycle. `hold` stays high.
- R7: During readout, `hold` stays high until `readout_done` is sampled, and it goes low on the cycle after that. `readout_done` is honoured even in the first readout cycle.
- R8: A pretrigger sampled while waiting or reading out has no effect. The window is not restarted and `readout_start` does not pulse.
- R9: A level-1 sampled while idle, and a `readout_done` sampled outside readout, have no effect on any output.
- R10: `busy` equals `hold` on every cycle. Both are high exactly when the block is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pretrigger | input | 1 | Fast early trigger that arms hold |
| level1 | input | 1 | Level-1 accept |
| readout_done | input | 1 | Readout sequencer finished |
| hold | output | 1 | Shared hold line to all channels |
| readout_start | output | 1 | One-cycle readout request |
| busy | output | 1 | High whenever not idle |

## Verification
The bench aims at the window edges:
- A level-1 on the last window cycle must still start readout. An off-by-one timer would drop hold instead.
- A silent window must hold for exactly `WIN_CYCLES` cycles. A miscounted timer would release hold one cycle early or late.

It also fires a pretrigger on the very first idle cycle after a timeout. A design with a hidden recovery cycle would miss that event.

Further cases cover the inputs that must be ignored:
- A repeated pretrigger during the wait must not restart the window.
- A repeated pretrigger during readout must not pulse `readout_start` again.
- A level-1 or `readout_done` while idle must not change any output.

Finally, the bench asserts `readout_done` in the same cycle as `readout_start`. A design that needs one settled readout cycle first would keep hold high too long.

// File: rtl/hold_ctl_pkg.sv
package hold_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_L1 = 2'd1,
    ST_READOUT = 2'd2
  } hold_state_t;
endpackage

// File: rtl/hold_window_timer.sv
module hold_window_timer #(
  parameter int WIN_CYCLES = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = run && (cnt_q == LAST);
  assign cnt_en = run || (cnt_q != '0);

  always_comb begin
    if (run && !expire) cnt_d = cnt_q + CW'(1);
    else                cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4
  idle_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pretrigger,
  input  logic        level1,
  input  logic        readout_done,
  input  logic        expire,
  output hold_state_t state,
  output logic        hold,
  output logic        readout_start
);
  hold_state_t state_d;
  logic        start_d;

  always_comb begin
    state_d = state;
    start_d = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pretrigger) state_d = ST_WAIT_L1;
      end
      ST_WAIT_L1: begin
        if (level1) begin
          state_d = ST_READOUT;
          start_d = 1'b1;
        end else if (expire) begin
          state_d = ST_IDLE;
        end
      end
      ST_READOUT: begin
        if (readout_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      hold          <= 1'b0;
      readout_start <= 1'b0;
    end else begin
      state         <= state_d;
      hold          <= (state_d != ST_IDLE);
      readout_start <= start_d;
    end
  end

  // R2
  arm_on_pretrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && pretrigger) |=> hold);

  // R9
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !pretrigger) |=> !hold);

  // R6
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readout_start |=> !readout_start);

  // R7
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READOUT && readout_done) |=> !hold);

  // R8
  readout_ignores_pretrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READOUT && !readout_done) |=> (hold && !readout_start));
endmodule

// File: rtl/hold_gate_ctrl.sv
module hold_gate_ctrl
  import hold_ctl_pkg::*;
#(
  parameter int WIN_CYCLES = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pretrigger,
  input  logic level1,
  input  logic readout_done,
  output logic hold,
  output logic readout_start,
  output logic busy
);
  hold_state_t state;
  logic        expire;
  logic        in_wait;

  assign in_wait = (state == ST_WAIT_L1);
  assign busy    = (state != ST_IDLE);

  hold_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (in_wait),
    .expire (expire)
  );

  hold_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pretrigger    (pretrigger),
    .level1        (level1),
    .readout_done  (readout_done),
    .expire        (expire),
    .state         (state),
    .hold          (hold),
    .readout_start (readout_start)
  );

  initial begin
    // R3
    win_param_chk: assert (WIN_CYCLES >= 2);
  end

  // R10
  hold_busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold == busy);
endmodule

// File: tb/sim_hold_gate_ctrl.sv
module sim_hold_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 12;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pretrigger = 1'b0;
  logic level1 = 1'b0;
  logic readout_done = 1'b0;
  logic hold, readout_start, busy;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  int m_st = 0;
  int m_cnt = 0;
  bit m_start = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hold_gate_ctrl #(.WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .pretrigger(pretrigger), .level1(level1),
    .readout_done(readout_done), .hold(hold), .readout_start(readout_start),
    .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=%0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic int exp_hold(int st);
    return (st != 0) ? 1 : 0;
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic model_step(bit pt, bit l1, bit dn);
    m_start = 1'b0;
    case (m_st)
      0: if (pt) begin m_st = 1; m_cnt = 0; end
      1: begin
        if (l1) begin m_st = 2; m_start = 1'b1; m_cnt = 0; end
        else if (m_cnt == WIN-1) begin m_st = 0; m_cnt = 0; end
        else m_cnt++;
      end
      default: if (dn) m_st = 0;
    endcase
  endtask

  task automatic step(bit pt, bit l1, bit dn, string tag);
    pretrigger = pt; level1 = l1; readout_done = dn;
    @(posedge clk);
    model_step(pt, l1, dn);
    @(negedge clk);
    chk(tag, "hold", hold, 1'(exp_hold(m_st)));
    chk(tag, "busy", busy, 1'(exp_hold(m_st)));
    chk(tag, "readout_start", readout_start, m_start);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "hold in reset", hold, 1'b0);
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "readout_start in reset", readout_start, 1'b0);
    rst_n = 1'b1;
    step(0, 0, 0, "R1");

    // R9: level1 and readout_done while idle are ignored
    step(0, 1, 0, "R9");
    step(0, 0, 1, "R9");
    step(0, 1, 1, "R9");

    // R2 arm, R3 hold through window, R4 timeout
    step(1, 0, 0, "R2");
    for (int k = 0; k < WIN-1; k++) step(0, 0, 0, "R3");
    step(0, 0, 0, "R4");
    chk("R4", "hold after silent window", hold, 1'b0);

    // R5: rearm on first idle cycle, then R8 pretrigger during wait
    step(1, 0, 0, "R5");
    chk("R5", "hold rearmed", hold, 1'b1);
    for (int k = 0; k < 4; k++) step(1, 0, 0, "R8");
    for (int k = 0; k < WIN-5; k++) step(0, 0, 1, "R9");
    step(0, 0, 0, "R8");
    chk("R8", "window not restarted", hold, 1'b0);

    // R6 level1 on last window cycle, R8 pretrigger in readout, R7 done
    step(1, 0, 0, "R2");
    for (int k = 0; k < WIN-1; k++) step(0, 0, 0, "R3");
    step(0, 1, 0, "R6");
    chk("R6", "start on last window cycle", readout_start, 1'b1);
    step(1, 0, 0, "R8");
    step(1, 1, 0, "R8");
    for (int k = 0; k < 5; k++) step(0, 0, 0, "R7");
    step(0, 0, 1, "R7");
    chk("R7", "hold released after done", hold, 1'b0);

    // R7: done in the same cycle as the start pulse
    step(1, 0, 0, "R2");
    step(0, 1, 0, "R6");
    step(0, 0, 1, "R7");
    chk("R7", "early done honoured", hold, 1'b0);

    // Random mix; R10 busy tracks hold throughout
    for (int i = 0; i < 4000; i++) begin
      bit pt, l1, dn;
      pt = (($urandom % 8) == 0);
      l1 = (($urandom % 20) == 0);
      dn = (($urandom % 6) == 0);
      step(pt, l1, dn, "R10");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule